// File: doc/BRIEF.md
# PN-Correlated Packet Framing Detector

This block sits on the receive side of a spread-spectrum link and watches a stream of despread chips for the start of a packet. It slides a chip window past a programmable start code and scores each position by the number of chips that differ from the code. When that score is within a 5-bit threshold, it takes the position as a first start symbol. It then expects a second copy of the code on the very next symbol boundary. Only when both symbols pass does it report a frame start.

When start framing is turned off, the same two-symbol test runs against a 32-chip data code. When the length option is on, the eight values that follow the second symbol are gathered MSB first into a length byte. These values arrive one per valid strobe on the same input. A header-done pulse marks the end of the header, whether or not a length byte was expected.

Configuration inputs are expected to stay steady while a packet is being framed.

Top module: `pn_frame_detector`

## Requirements
- R1: During and right after reset, frame_start, hdr_done and len_vld are low and len_val is zero.
- R2: The start code is 64 chips long when sop_long is 1 and 32 chips long when it is 0. In short mode the upper half of sop_code is unused. The chip that arrives first is compared with code bit N-1, and the newest chip with code bit 0.
- R3: A symbol matches when its count of mismatching chips is at most the threshold. With sop_long=1 all five bits of sop_thresh apply. In 32-chip modes bit 4 of sop_thresh is treated as zero.
- R4: A frame is reported only when a first symbol matches and the N chips that follow, taken as one symbol, also match. Each symbol is checked against the same threshold separately.
- R5: While hunting, the match is tested at every valid chip. If the second symbol fails, the block goes back to hunting and no frame_start is given.
- R6: frame_start is a one-cycle pulse, high in the cycle after the clock edge that accepts the last chip of the second symbol.
- R7: With sop_en=0 the two symbols are matched against the 32-bit data_code, with bit 4 of the threshold treated as zero.
- R8: With len_en=1, the 8 valid chips that follow the second symbol form len_val, MSB first. len_vld and a one-cycle hdr_done appear in the cycle after the eighth chip's edge. len_vld stays high until the next frame_start, which clears it.
- R9: With len_en=0, hdr_done pulses in the same cycle as frame_start and len_vld stays low.
- R10: A cycle with chip_vld low consumes no chip. It raises no pulse, and it leaves the window, counters and len_val unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_vld | input | 1 | chip_in carries a chip this cycle |
| chip_in | input | 1 | Despread chip or header bit |
| sop_code | input | 64 | Start code; bits 31:0 only in short mode |
| data_code | input | 32 | Data code used when start framing is off |
| sop_en | input | 1 | 1: match the start code; 0: match the data code |
| sop_long | input | 1 | 1: 64-chip start code; 0: 32-chip |
| len_en | input | 1 | 1: a length byte follows the second symbol |
| sop_thresh | input | 5 | Largest mismatch count that still matches |
| frame_start | output | 1 | Pulse: two symbols matched |
| len_val | output | 8 | Captured length byte |
| len_vld | output | 1 | len_val holds the current frame's length |
| hdr_done | output | 1 | Pulse: header complete |

## Verification
A wrong symbol counter or a window that slides by the wrong amount shows up as a frame_start that is missing or one strobe off, in the cycle after the second symbol's last chip. A threshold with the wrong width or masking changes which corrupted symbols are accepted, and shows at the same edge. A length capture with broken bit order or count shows as a wrong len_val, or as len_vld and hdr_done arriving at the wrong time, within eight strobes of the frame start. The bench runs a chip-history model alongside the design and compares all four outputs on every cycle, so any such fault shows the cycle it first reaches a port.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SECOND = 2'd1,
    ST_LENGTH = 2'd2
  } fd_state_e;
endpackage

// File: rtl/fd_chip_window.sv
module fd_chip_window #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chip_vld,
  input  logic         chip_in,
  output logic [W-1:0] window_next
);
  logic [W-1:0] win_q;

  // newest chip enters at bit 0
  assign window_next = {win_q[W-2:0], chip_in};

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= '0;
    else if (chip_vld) win_q <= window_next;
  end
endmodule

// File: rtl/fd_correlator.sv
module fd_correlator #(
  parameter int W     = 64,
  parameter int THR_W = 5
) (
  input  logic [W-1:0]     window,
  input  logic [W-1:0]     code,
  input  logic [W-1:0]     mask,
  input  logic [THR_W-1:0] thresh,
  output logic             hit
);
  localparam int DW   = $clog2(W + 1);
  localparam int CMPW = (DW > THR_W) ? DW : THR_W;

  function automatic logic [DW-1:0] ones(input logic [W-1:0] v);
    logic [DW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) acc = acc + DW'(v[i]);
    return acc;
  endfunction

  logic [DW-1:0] distance;

  assign distance = ones((window ^ code) & mask);
  assign hit      = CMPW'(distance) <= CMPW'(thresh);
endmodule

// File: rtl/fd_length_capture.sv
module fd_length_capture #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take_bit,
  input  logic             last_bit,
  input  logic             bit_in,
  output logic [LEN_W-1:0] len_val,
  output logic             len_vld
);
  logic [LEN_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      len_val <= '0;
      len_vld <= 1'b0;
    end else begin
      if (clear) len_vld <= 1'b0;
      if (take_bit) sh_q <= {sh_q[LEN_W-2:0], bit_in};
      if (last_bit) begin
        len_val <= {sh_q[LEN_W-2:0], bit_in};
        len_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fd_ctrl.sv
module fd_ctrl
  import fd_pkg::*;
#(
  parameter int SOP_W  = 64,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_vld,
  input  logic sop_en,
  input  logic sop_long,
  input  logic len_en,
  input  logic sym_hit,
  output logic frame_start,
  output logic hdr_done,
  output logic take_len_bit,
  output logic last_len_bit,
  output logic first_hit_evt,
  output logic second_hit_evt,
  output logic second_miss_evt
);
  localparam int CW  = $clog2(SOP_W);
  localparam int LCW = $clog2(LEN_W);

  fd_state_e       st_q;
  logic [CW-1:0]   cnt_q;
  logic [LCW-1:0]  bcnt_q;
  logic [CW-1:0]   sym_last;
  logic            at_boundary;

  always_comb begin
    if (!sop_en)       sym_last = CW'(DATA_W - 1);
    else if (sop_long) sym_last = CW'(SOP_W - 1);
    else               sym_last = CW'(SOP_W / 2 - 1);
  end

  assign first_hit_evt   = (st_q == ST_HUNT) && chip_vld && sym_hit;
  assign at_boundary     = (st_q == ST_SECOND) && chip_vld && (cnt_q == sym_last);
  assign second_hit_evt  = at_boundary && sym_hit;
  assign second_miss_evt = at_boundary && !sym_hit;
  assign take_len_bit    = (st_q == ST_LENGTH) && chip_vld;
  assign last_len_bit    = take_len_bit && (bcnt_q == LCW'(LEN_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_HUNT;
      cnt_q       <= '0;
      bcnt_q      <= '0;
      frame_start <= 1'b0;
      hdr_done    <= 1'b0;
    end else begin
      frame_start <= second_hit_evt;
      hdr_done    <= (second_hit_evt && !len_en) || last_len_bit;
      unique case (st_q)
        ST_HUNT: begin
          if (first_hit_evt) begin
            st_q  <= ST_SECOND;
            cnt_q <= '0;
          end
        end
        ST_SECOND: begin
          if (second_hit_evt) begin
            st_q   <= len_en ? ST_LENGTH : ST_HUNT;
            bcnt_q <= '0;
          end else if (second_miss_evt) begin
            st_q <= ST_HUNT;
          end else if (chip_vld) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LENGTH: begin
          if (last_len_bit)      st_q   <= ST_HUNT;
          else if (take_len_bit) bcnt_q <= bcnt_q + 1'b1;
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/pn_frame_detector.sv
module pn_frame_detector #(
  parameter int SOP_W  = 64,
  parameter int DATA_W = 32,
  parameter int THR_W  = 5,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_vld,
  input  logic              chip_in,
  input  logic [SOP_W-1:0]  sop_code,
  input  logic [DATA_W-1:0] data_code,
  input  logic              sop_en,
  input  logic              sop_long,
  input  logic              len_en,
  input  logic [THR_W-1:0]  sop_thresh,
  output logic              frame_start,
  output logic [LEN_W-1:0]  len_val,
  output logic              len_vld,
  output logic              hdr_done
);
  localparam int SHORT_W = SOP_W / 2;

  logic [SOP_W-1:0] window_next;
  logic [SOP_W-1:0] sop_mask;
  logic [THR_W-1:0] thr_short;
  logic [THR_W-1:0] thr_sop;
  logic             sop_hit;
  logic             data_hit;
  logic             sym_hit;
  logic             take_len_bit;
  logic             last_len_bit;
  logic             first_hit_evt;
  logic             second_hit_evt;
  logic             second_miss_evt;

  // 32-chip modes drop the threshold MSB
  assign thr_short = {1'b0, sop_thresh[THR_W-2:0]};
  assign thr_sop   = sop_long ? sop_thresh : thr_short;
  assign sop_mask  = sop_long ? {SOP_W{1'b1}} : {{SHORT_W{1'b0}}, {SHORT_W{1'b1}}};
  assign sym_hit   = sop_en ? sop_hit : data_hit;

  fd_chip_window #(.W(SOP_W)) u_window (
    .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .chip_in(chip_in),
    .window_next(window_next)
  );

  fd_correlator #(.W(SOP_W), .THR_W(THR_W)) u_sop_corr (
    .window(window_next), .code(sop_code), .mask(sop_mask),
    .thresh(thr_sop), .hit(sop_hit)
  );

  fd_correlator #(.W(DATA_W), .THR_W(THR_W)) u_data_corr (
    .window(window_next[DATA_W-1:0]), .code(data_code),
    .mask({DATA_W{1'b1}}), .thresh(thr_short), .hit(data_hit)
  );

  fd_ctrl #(.SOP_W(SOP_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .sop_en(sop_en),
    .sop_long(sop_long), .len_en(len_en), .sym_hit(sym_hit),
    .frame_start(frame_start), .hdr_done(hdr_done),
    .take_len_bit(take_len_bit), .last_len_bit(last_len_bit),
    .first_hit_evt(first_hit_evt), .second_hit_evt(second_hit_evt),
    .second_miss_evt(second_miss_evt)
  );

  fd_length_capture #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(second_hit_evt),
    .take_bit(take_len_bit), .last_bit(last_len_bit), .bit_in(chip_in),
    .len_val(len_val), .len_vld(len_vld)
  );
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_vld,
  input logic             len_en,
  input logic             frame_start,
  input logic             hdr_done,
  input logic             len_vld,
  input logic [LEN_W-1:0] len_val,
  input logic             second_miss_evt
);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R6
  start_after_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(chip_vld));

  // R5
  miss_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_miss_evt |=> !frame_start);

  // R8
  len_rise_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_vld) |-> hdr_done);

  // R8
  start_clears_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !len_vld);

  // R9
  nolen_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !len_en) |-> hdr_done);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_vld |=> (!frame_start && !hdr_done && $stable(len_val)));
endmodule

bind pn_frame_detector fd_checker #(.LEN_W(LEN_W)) u_fd_chk (
  .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .len_en(len_en),
  .frame_start(frame_start), .hdr_done(hdr_done), .len_vld(len_vld),
  .len_val(len_val), .second_miss_evt(second_miss_evt)
);

// File: tb/tb_pn_frame_detector.sv
module tb_pn_frame_detector;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SOPC  = 64'h3C5A_96E1_2B7D_C084;
  localparam logic [31:0] DATAC = 32'h6D2B_94F1;

  typedef struct packed {
    logic       sop_en;
    logic       lng;
    logic       len_en;
    logic [4:0] thr;
    logic [6:0] e1;
    logic [6:0] e2;
    logic [7:0] lenb;
    logic       gaps;
    logic [1:0] want;   // 0 no frame, 1 frame, 2 either
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 5'd4,  7'd0,  7'd0,  8'hA5, 1'b0, 2'd1}, // R2 R8 clean short
    '{1'b1, 1'b0, 1'b1, 5'd4,  7'd4,  7'd3,  8'h3C, 1'b0, 2'd1}, // R3 at threshold
    '{1'b1, 1'b0, 1'b1, 5'd4,  7'd5,  7'd0,  8'h11, 1'b0, 2'd0}, // R3 over threshold
    '{1'b1, 1'b0, 1'b1, 5'd4,  7'd0,  7'd5,  8'h22, 1'b0, 2'd0}, // R4 R5 second miss
    '{1'b1, 1'b0, 1'b1, 5'h14, 7'd6,  7'd0,  8'h33, 1'b0, 2'd0}, // R3 MSB ignored
    '{1'b1, 1'b1, 1'b1, 5'd14, 7'd14, 7'd14, 8'hC3, 1'b0, 2'd1}, // R2 long
    '{1'b1, 1'b1, 1'b1, 5'd14, 7'd0,  7'd15, 8'h44, 1'b0, 2'd0}, // R4 long miss
    '{1'b1, 1'b1, 1'b1, 5'h14, 7'd20, 7'd20, 8'h96, 1'b0, 2'd1}, // R3 MSB used long
    '{1'b1, 1'b1, 1'b0, 5'd4,  7'd0,  7'd0,  8'h00, 1'b0, 2'd1}, // R9
    '{1'b0, 1'b0, 1'b1, 5'd3,  7'd3,  7'd0,  8'h81, 1'b0, 2'd1}, // R7 data code
    '{1'b0, 1'b0, 1'b1, 5'd3,  7'd0,  7'd4,  8'h55, 1'b0, 2'd0}, // R7 data miss
    '{1'b0, 1'b0, 1'b1, 5'h13, 7'd4,  7'd0,  8'h66, 1'b0, 2'd0}, // R7 MSB ignored
    '{1'b1, 1'b0, 1'b1, 5'd4,  7'd2,  7'd1,  8'h5A, 1'b1, 2'd1}  // R10 gaps
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_vld = 1'b0;
  logic        chip_in = 1'b0;
  logic        sop_en = 1'b1, sop_long = 1'b0, len_en = 1'b1;
  logic [4:0]  sop_thresh = 5'd4;
  logic        frame_start, len_vld, hdr_done;
  logic [7:0]  len_val;

  int n_chk = 0, n_bad = 0, dets = 0;
  bit exp_fs, exp_hd, exp_lv;
  bit [7:0] exp_lval;
  bit hist [64];
  int mst, mcnt, mbcnt;
  bit [7:0] mlsh;

  always #(CLK_PERIOD/2) clk = ~clk;

  pn_frame_detector dut (
    .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .chip_in(chip_in),
    .sop_code(SOPC), .data_code(DATAC), .sop_en(sop_en), .sop_long(sop_long),
    .len_en(len_en), .sop_thresh(sop_thresh), .frame_start(frame_start),
    .len_val(len_val), .len_vld(len_vld), .hdr_done(hdr_done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) hist[i] = 1'b0;
    mst = 0; mcnt = 0; mbcnt = 0; mlsh = '0;
    exp_fs = 0; exp_hd = 0; exp_lv = 0; exp_lval = '0;
  endtask

  // reference: counts mismatches over a chip history, newest at index 0
  task automatic model_step(input bit v, input bit c);
    int n, th, mism;
    bit hit, refb;
    exp_fs = 0; exp_hd = 0;
    if (!v) return;
    for (int i = 63; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = c;
    n  = !sop_en ? 32 : (sop_long ? 64 : 32);
    th = (sop_en && sop_long) ? int'(sop_thresh) : int'(sop_thresh) % 16;
    mism = 0;
    for (int i = 0; i < n; i++) begin
      refb = sop_en ? SOPC[i] : DATAC[i];
      if (hist[i] != refb) mism++;
    end
    hit = (mism <= th);
    if (mst == 0) begin
      if (hit) begin mst = 1; mcnt = 0; end
    end else if (mst == 1) begin
      mcnt++;
      if (mcnt == n) begin
        if (hit) begin
          exp_fs = 1; exp_lv = 0; dets++;
          if (len_en) begin mst = 2; mbcnt = 0; end
          else begin exp_hd = 1; mst = 0; end
        end else mst = 0;
      end
    end else begin
      mlsh = {mlsh[6:0], c};
      mbcnt++;
      if (mbcnt == 8) begin
        exp_lv = 1; exp_lval = mlsh; exp_hd = 1; mst = 0;
      end
    end
  endtask

  task automatic compare_now(input string req);
    check(req, "frame_start", int'(frame_start), int'(exp_fs));
    check(req, "hdr_done", int'(hdr_done), int'(exp_hd));
    check(req, "len_vld", int'(len_vld), int'(exp_lv));
    if (exp_lv) check(req, "len_val", int'(len_val), int'(exp_lval));
  endtask

  task automatic step(input bit v, input bit c, input string req);
    @(negedge clk);
    compare_now(req);
    chip_vld = v; chip_in = c;
    model_step(v, c);
  endtask

  task automatic send(input logic [63:0] bits, input int n, input bit gaps, input string req);
    for (int i = n - 1; i >= 0; i--) begin
      if (gaps && (i % 3 == 0)) step(1'b0, 1'b1, req);
      step(1'b1, bits[i], req);
    end
  endtask

  function automatic logic [63:0] flip(input logic [63:0] sym, input int n, input int e);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < e; i++) m[n-1-i] = 1'b1;
    return sym ^ m;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "frame_start", int'(frame_start), 0);
    check("R1", "hdr_done", int'(hdr_done), 0);
    check("R1", "len_vld", int'(len_vld), 0);
    check("R1", "len_val", int'(len_val), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      vec_t vv;
      int n, d0;
      logic [63:0] code;
      vv = VECS[k];
      sop_en = vv.sop_en; sop_long = vv.lng; len_en = vv.len_en; sop_thresh = vv.thr;
      n    = (vv.sop_en && vv.lng) ? 64 : 32;
      code = vv.sop_en ? SOPC : {32'h0, DATAC};
      if (n == 32) code[63:32] = '0;
      d0 = dets;
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R5");
      send(flip(code, n, int'(vv.e1)), n, vv.gaps, "R4");
      send(flip(code, n, int'(vv.e2)), n, vv.gaps, "R6");
      send({56'h0, vv.lenb}, 8, vv.gaps, "R8");
      for (int i = 0; i < 70; i++) step(1'b1, 1'b0, "R5");
      if (vv.want != 2'd2)
        check(vv.sop_en ? "R4" : "R7", "frame seen", int'(dets > d0), int'(vv.want));
    end

    // R10: idle cycles in the length phase hold state and give no pulse
    sop_en = 1'b1; sop_long = 1'b0; len_en = 1'b1; sop_thresh = 5'd4;
    send(SOPC, 32, 1'b0, "R10");
    send(SOPC, 32, 1'b0, "R10");
    send(64'h3, 4, 1'b0, "R10");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R10");
    send(64'h9, 4, 1'b0, "R10");
    step(1'b0, 1'b0, "R10");
    check("R8", "len byte", int'(len_val), 8'h39);

    // R1: reset in the middle of a second symbol
    send(SOPC, 32, 1'b0, "R1");
    send(SOPC, 16, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b0; chip_vld = 1'b0;
    @(negedge clk);
    model_reset();
    check("R1", "len_vld after reset", int'(len_vld), 0);
    check("R1", "len_val after reset", int'(len_val), 0);
    check("R1", "frame_start after reset", int'(frame_start), 0);
    rst_n = 1'b1;
    send(SOPC, 16, 1'b0, "R1");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, "R1");
    @(negedge clk);
    compare_now("R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule